// File: doc/BRIEF.md
# Track Format Table and Sector Mapper

This block takes in the byte stream that lays out one track during a format operation. It then serves as the map from logical sector number to physical sector slot. Each physical slot is described by two bytes: a condition flag and the logical number that slot will carry. Only the first N pairs count, where N is the entry count loaded when the format begins. The bytes after the table are filler. They must still be supplied, because the map takes effect only once the whole sector-sized buffer has been received.

Once the map is ready, a lookup presents a logical sector number. One cycle later the block answers with the physical slot holding that number, whether the slot is marked bad, or that no slot holds it. The block is meant to sit between the task-file logic that starts a format and the read/write sequencer. The sequencer raises the bad-block status when an access lands on a bad slot.

Top module: `track_fmt_mapper`

## Requirements
- R1: After reset, fmt_busy, map_ready, fmt_done and rsp_valid are all 0.
- R2: A fmt_start pulse latches fmt_count, sets fmt_busy and clears map_ready from the next cycle, and restarts byte capture at byte 0, even in the middle of an earlier capture.
- R3: During capture, byte 2k is the flag of slot k and byte 2k+1 is its logical number, for k below the latched count. Bytes past the table are filler and change no entry.
- R4: The BUF_BYTES-th accepted byte ends the capture. In the cycle after it, map_ready is 1 and fmt_done pulses for exactly that one cycle. One byte earlier, map_ready is still 0.
- R5: A flag byte of 0x00 marks a slot good. Any other value, 0x80 included, marks the slot bad.
- R6: A lookup with lk_valid=1 gives rsp_valid=1 in the following cycle. When found, rsp_slot is the lowest slot below the count whose logical number equals lk_sector.
- R7: rsp_found is 0 when no valid entry matches, when the map is not ready (before the first format or during a capture), or when the count is 0.
- R8: rsp_bad is 1 exactly when the found slot is flagged bad. It is never 1 without rsp_found.
- R9: wr_valid while no capture is in progress changes no map entry.
- R10: A count above MAX_ENT is clamped to MAX_ENT entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_start | input | 1 | Begin a new format capture |
| fmt_count | input | 8 | Number of table entries, sampled with fmt_start |
| wr_valid | input | 1 | Format byte present |
| wr_byte | input | 8 | Format byte |
| lk_valid | input | 1 | Lookup request |
| lk_sector | input | 8 | Logical sector number to look up |
| fmt_busy | output | 1 | Capture in progress |
| map_ready | output | 1 | Map is complete and usable |
| fmt_done | output | 1 | One-cycle pulse when capture completes |
| rsp_valid | output | 1 | Lookup answer present |
| rsp_found | output | 1 | Logical number was found |
| rsp_bad | output | 1 | Found slot is marked bad |
| rsp_slot | output | 7 | Physical slot of the match (0 when not found) |

## Verification
A byte index that drifts shows up at the ports as map_ready rising one or more bytes early or late, so the bench samples readiness on the byte before the last and on the last byte itself. A pair decoded in the wrong order, or filler written into the table, shows up on the very next lookup as a wrong slot, a wrong bad flag, or a hit on a number that only the filler holds. A wrong priority among duplicate entries, or a count bound that is off by one, changes the slot returned one cycle after the request.

// File: rtl/tfm_pkg.sv
package tfm_pkg;
    typedef logic [7:0] byte_t;

    typedef struct packed {
        logic  bad;
        byte_t lsn;
    } map_entry_t;
endpackage

// File: rtl/tfm_capture.sv
module tfm_capture
    import tfm_pkg::*;
#(
    parameter int BUF_BYTES = 256,
    parameter int MAX_ENT   = 128,
    localparam int IDX_W    = $clog2(BUF_BYTES),
    localparam int SLOT_W   = $clog2(MAX_ENT),
    localparam int CNT_W    = $clog2(MAX_ENT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fmt_start,
    input  logic [7:0]       fmt_count,
    input  logic             wr_valid,
    input  byte_t            wr_byte,
    output logic             busy_o,
    output logic             ready_o,
    output logic             done_o,
    output logic [CNT_W-1:0] count_o,
    output map_entry_t       tbl_o [MAX_ENT]
);
    typedef struct {
        logic             busy;
        logic             ready;
        logic             done;
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] count;
        map_entry_t       tbl [MAX_ENT];
    } cap_state_t;

    cap_state_t s_d, s_q;

    always_comb begin
        logic [IDX_W-2:0] pair;
        s_d      = s_q;
        s_d.done = 1'b0;
        pair     = s_q.idx[IDX_W-1:1];
        if (fmt_start) begin
            s_d.busy  = 1'b1;
            s_d.ready = 1'b0;
            s_d.idx   = '0;
            s_d.count = (int'(fmt_count) > MAX_ENT) ? CNT_W'(MAX_ENT) : CNT_W'(fmt_count);
        end else if (s_q.busy && wr_valid) begin
            if (int'(pair) < int'(s_q.count)) begin
                if (s_q.idx[0]) begin
                    s_d.tbl[pair[SLOT_W-1:0]].lsn = wr_byte;
                end else begin
                    s_d.tbl[pair[SLOT_W-1:0]].bad = (wr_byte != 8'h00);
                end
            end
            if (s_q.idx == IDX_W'(BUF_BYTES - 1)) begin
                s_d.busy  = 1'b0;
                s_d.ready = 1'b1;
                s_d.done  = 1'b1;
                s_d.idx   = '0;
            end else begin
                s_d.idx = s_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.busy  <= 1'b0;
            s_q.ready <= 1'b0;
            s_q.done  <= 1'b0;
            s_q.idx   <= '0;
            s_q.count <= '0;
            for (int i = 0; i < MAX_ENT; i++) begin
                s_q.tbl[i] <= '0;
            end
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o  = s_q.busy;
    assign ready_o = s_q.ready;
    assign done_o  = s_q.done;
    assign count_o = s_q.count;
    assign tbl_o   = s_q.tbl;

    // R4: the completion pulse only comes with a usable map
    a_r4_done_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> s_q.ready);
    // R4: a capture in progress and a ready map never coexist
    a_r4_busy_excl_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_q.busy && s_q.ready));
    // R2: a start always opens a fresh capture
    a_r2_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_start |=> (s_q.busy && !s_q.ready && s_q.idx == '0));
    // R10: the latched count never exceeds the table size
    a_r10_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        int'(s_q.count) <= MAX_ENT);
endmodule

// File: rtl/tfm_search.sv
module tfm_search
    import tfm_pkg::*;
#(
    parameter int MAX_ENT  = 128,
    localparam int SLOT_W  = $clog2(MAX_ENT),
    localparam int CNT_W   = $clog2(MAX_ENT + 1)
) (
    input  map_entry_t        tbl [MAX_ENT],
    input  logic [CNT_W-1:0]  count,
    input  byte_t             key,
    output logic              hit,
    output logic [SLOT_W-1:0] slot,
    output logic              bad
);
    // Scan from the top down so that the lowest matching slot wins.
    always_comb begin
        hit  = 1'b0;
        slot = '0;
        bad  = 1'b0;
        for (int i = MAX_ENT - 1; i >= 0; i--) begin
            if ((i < int'(count)) && (tbl[i].lsn == key)) begin
                hit  = 1'b1;
                slot = SLOT_W'(i);
                bad  = tbl[i].bad;
            end
        end
    end
endmodule

// File: rtl/track_fmt_mapper.sv
module track_fmt_mapper
    import tfm_pkg::*;
#(
    parameter int BUF_BYTES = 256,
    parameter int MAX_ENT   = 128,
    localparam int SLOT_W   = $clog2(MAX_ENT),
    localparam int CNT_W    = $clog2(MAX_ENT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fmt_start,
    input  logic [7:0]        fmt_count,
    input  logic              wr_valid,
    input  logic [7:0]        wr_byte,
    input  logic              lk_valid,
    input  logic [7:0]        lk_sector,
    output logic              fmt_busy,
    output logic              map_ready,
    output logic              fmt_done,
    output logic              rsp_valid,
    output logic              rsp_found,
    output logic              rsp_bad,
    output logic [SLOT_W-1:0] rsp_slot
);
    typedef struct packed {
        logic              valid;
        logic              found;
        logic              bad;
        logic [SLOT_W-1:0] slot;
    } rsp_t;

    map_entry_t        tbl [MAX_ENT];
    logic [CNT_W-1:0]  count;
    logic              hit;
    logic              hit_bad;
    logic [SLOT_W-1:0] hit_slot;
    rsp_t              rsp_d, rsp_q;

    tfm_capture #(.BUF_BYTES(BUF_BYTES), .MAX_ENT(MAX_ENT)) capture_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fmt_start (fmt_start),
        .fmt_count (fmt_count),
        .wr_valid  (wr_valid),
        .wr_byte   (wr_byte),
        .busy_o    (fmt_busy),
        .ready_o   (map_ready),
        .done_o    (fmt_done),
        .count_o   (count),
        .tbl_o     (tbl)
    );

    tfm_search #(.MAX_ENT(MAX_ENT)) search_i (
        .tbl   (tbl),
        .count (count),
        .key   (lk_sector),
        .hit   (hit),
        .slot  (hit_slot),
        .bad   (hit_bad)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = lk_valid;
        rsp_d.found = lk_valid && map_ready && hit;
        rsp_d.bad   = rsp_d.found && hit_bad;
        rsp_d.slot  = rsp_d.found ? hit_slot : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_found = rsp_q.found;
    assign rsp_bad   = rsp_q.bad;
    assign rsp_slot  = rsp_q.slot;

    // R6: every request is answered in the next cycle
    a_r6_answer_next: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    // R7: no hit can come back while the map is not ready
    a_r7_no_hit_unready: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !map_ready) |=> !rsp_found);
    // R8: the bad marker is only given with a hit
    a_r8_bad_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_bad |-> (rsp_found && rsp_valid));
endmodule

// File: tb/track_fmt_mapper_tb_top.sv
module track_fmt_mapper_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BUF        = 256;

    typedef struct packed {
        logic [7:0] key;
        logic       found;
        logic [6:0] slot;
        logic       bad;
    } vec_t;

    // Lookups on the 32-entry 4:1 interleave map; slot 5 flag 0x80, slot 7 flag 0x41.
    localparam vec_t VECS [12] = '{
        '{8'd0,  1'b1, 7'd0,  1'b0},
        '{8'd8,  1'b1, 7'd1,  1'b0},
        '{8'd1,  1'b1, 7'd4,  1'b0},
        '{8'd9,  1'b1, 7'd5,  1'b1},
        '{8'd25, 1'b1, 7'd7,  1'b1},
        '{8'd16, 1'b1, 7'd2,  1'b0},
        '{8'd31, 1'b1, 7'd31, 1'b0},
        '{8'd24, 1'b1, 7'd3,  1'b0},
        '{8'd17, 1'b1, 7'd6,  1'b0},
        '{8'd2,  1'b1, 7'd8,  1'b0},
        '{8'd40, 1'b0, 7'd0,  1'b0},
        '{8'd32, 1'b0, 7'd0,  1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fmt_start = 1'b0;
    logic [7:0] fmt_count = 8'd0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_byte = 8'd0;
    logic       lk_valid = 1'b0;
    logic [7:0] lk_sector = 8'd0;
    logic       fmt_busy, map_ready, fmt_done, rsp_valid, rsp_found, rsp_bad;
    logic [6:0] rsp_slot;

    logic [7:0] fmt_bytes [BUF];
    int         checks = 0;
    int         errors = 0;
    bit         finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    track_fmt_mapper dut_i (
        .clk (clk), .rst_n (rst_n), .fmt_start (fmt_start), .fmt_count (fmt_count),
        .wr_valid (wr_valid), .wr_byte (wr_byte), .lk_valid (lk_valid), .lk_sector (lk_sector),
        .fmt_busy (fmt_busy), .map_ready (map_ready), .fmt_done (fmt_done),
        .rsp_valid (rsp_valid), .rsp_found (rsp_found), .rsp_bad (rsp_bad), .rsp_slot (rsp_slot)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_format(input logic [7:0] cnt, input bit edge_chk, input string req);
        @(negedge clk);
        fmt_start = 1'b1;
        fmt_count = cnt;
        @(negedge clk);
        fmt_start = 1'b0;
        if (edge_chk) begin
            check("R2", {req, " busy after start"}, 32'(fmt_busy), 32'd1);
            check("R2", {req, " ready cleared"}, 32'(map_ready), 32'd0);
        end
        for (int b = 0; b < BUF; b++) begin
            wr_valid = 1'b1;
            wr_byte  = fmt_bytes[b];
            @(posedge clk);
            #1;
            if (edge_chk && b == BUF - 2) check("R4", {req, " ready one byte early"}, 32'(map_ready), 32'd0);
            if (edge_chk && b == BUF - 1) begin
                check("R4", {req, " ready on last byte"}, 32'(map_ready), 32'd1);
                check("R4", {req, " done pulse"}, 32'(fmt_done), 32'd1);
            end
            @(negedge clk);
        end
        wr_valid = 1'b0;
        if (edge_chk) begin
            @(posedge clk);
            #1;
            check("R4", {req, " done lasts one cycle"}, 32'(fmt_done), 32'd0);
        end
    endtask

    task automatic lookup(input logic [7:0] key, input logic found, input logic [6:0] slot,
                          input logic bad, input string req);
        @(negedge clk);
        lk_valid  = 1'b1;
        lk_sector = key;
        @(posedge clk);
        #1;
        check("R6", $sformatf("valid key %0d", key), 32'(rsp_valid), 32'd1);
        check(req, $sformatf("found key %0d", key), 32'(rsp_found), 32'(found));
        if (found) begin
            check(req, $sformatf("slot key %0d", key), 32'(rsp_slot), 32'(slot));
            check("R8", $sformatf("bad key %0d", key), 32'(rsp_bad), 32'(bad));
        end else begin
            check("R8", $sformatf("no bad on miss key %0d", key), 32'(rsp_bad), 32'd0);
        end
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1", "busy", 32'(fmt_busy), 32'd0);
        check("R1", "ready", 32'(map_ready), 32'd0);
        check("R1", "done", 32'(fmt_done), 32'd0);
        check("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R7: no map yet
        lookup(8'd0, 1'b0, 7'd0, 1'b0, "R7");

        // Scenario A: 32 entries, 4:1 interleave, filler 0x28 (R3, R5)
        for (int p = 0; p < BUF / 2; p++) begin
            fmt_bytes[2*p]   = 8'h28;
            fmt_bytes[2*p+1] = 8'h28;
        end
        for (int p = 0; p < 32; p++) begin
            fmt_bytes[2*p]   = (p == 5) ? 8'h80 : ((p == 7) ? 8'h41 : 8'h00);
            fmt_bytes[2*p+1] = 8'((p % 4) * 8 + p / 4);
        end
        run_format(8'd32, 1'b1, "A");
        for (int v = 0; v < 12; v++) begin
            lookup(VECS[v].key, VECS[v].found, VECS[v].slot, VECS[v].bad,
                   VECS[v].found ? "R6" : "R3");
        end

        // R9: stray writes while idle must not reach slot 0
        @(negedge clk);
        wr_valid = 1'b1; wr_byte = 8'h80;
        @(negedge clk);
        wr_byte = 8'h05;
        @(negedge clk);
        wr_valid = 1'b0;
        lookup(8'd0, 1'b1, 7'd0, 1'b0, "R9");
        lookup(8'd5, 1'b1, 7'd20, 1'b0, "R9");

        // R2: abandoned capture, lookup mid-capture (R7), then restart
        @(negedge clk);
        fmt_start = 1'b1; fmt_count = 8'd3;
        @(negedge clk);
        fmt_start = 1'b0;
        for (int b = 0; b < 10; b++) begin
            wr_valid = 1'b1; wr_byte = 8'hFF;
            @(negedge clk);
        end
        wr_valid = 1'b0;
        lookup(8'd0, 1'b0, 7'd0, 1'b0, "R7");
        for (int b = 0; b < BUF; b++) fmt_bytes[b] = 8'h00;
        fmt_bytes[1] = 8'd3;
        fmt_bytes[2] = 8'h80; fmt_bytes[3] = 8'd7;
        fmt_bytes[4] = 8'h00; fmt_bytes[5] = 8'd7;
        fmt_bytes[6] = 8'h00; fmt_bytes[7] = 8'd9;
        run_format(8'd3, 1'b1, "R2 restart");
        lookup(8'd7, 1'b1, 7'd1, 1'b1, "R6");
        lookup(8'd3, 1'b1, 7'd0, 1'b0, "R2");
        lookup(8'd9, 1'b0, 7'd0, 1'b0, "R3");

        // R7: count zero gives an empty map
        run_format(8'd0, 1'b0, "zero");
        lookup(8'd0, 1'b0, 7'd0, 1'b0, "R7");

        // R10: count 200 clamps to 128 entries, logical = slot
        for (int p = 0; p < BUF / 2; p++) begin
            fmt_bytes[2*p]   = 8'h00;
            fmt_bytes[2*p+1] = 8'(p);
        end
        run_format(8'd200, 1'b0, "clamp");
        lookup(8'd127, 1'b1, 7'd127, 1'b0, "R10");
        lookup(8'd0, 1'b1, 7'd0, 1'b0, "R10");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule